// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

This block runs once after power-up, or whenever software asks, to find the erase blocks of a small NAND flash that were marked unusable at the factory. It walks the 128 blocks in ascending order and, for each one, asks a flash controller to read the marker byte at column 0 of the block's first page and, if that byte is clean, of its second page. Any marker value other than the erased value FFh condemns the block. Block 0 is always good, whatever its markers hold.

The results go into a one-bit-per-block table. Once the scan completes, a lookup port reports whether any given block may be used. A warning output is raised when more than three blocks are condemned, because the array never ships with that many bad blocks. Requests go out as single-cycle pulses carrying a 19-bit byte address. The block then waits, for as long as it takes, for a matching response pulse carrying the byte that was read.

Top module: `badblk_scanner`

## Requirements
- R1: After reset, `done`, `busy`, `req_valid`, `lookup_ok` and `excess_bad` are all 0.
- R2: A `start` pulse while idle clears the table and `done`. On the next cycle `busy` is 1 and the first request (block 0, page 0) is issued.
- R3: Each request is a one-cycle `req_valid` pulse. `req_addr` equals block*4096 + page*128: bits 18:12 hold the block, bit 7 holds the page, and every other bit is 0 (marker column 0). No further request is issued until a `resp_valid` pulse has been taken.
- R4: Requests run through blocks 0 to 127 in ascending order, page 0 before page 1. Page 1 is not requested when the page-0 marker is not FFh.
- R5: A block other than block 0 is recorded invalid exactly when a marker byte read for it is not FFh. Any non-FFh value counts, including 00h, 7Fh and FEh.
- R6: Block 0 is never recorded invalid, even when its markers are not FFh.
- R7: `done` becomes 1, and `busy` becomes 0, in the cycle after the last response for block 127 is taken. `done` stays 1 until the next accepted `start`.
- R8: `lookup_ok` is registered. One cycle after `lookup_blk` is presented, it is 1 if `done` is set and that block is valid, and 0 otherwise. While `done` is 0, `lookup_ok` is always 0.
- R9: `excess_bad` is 1 exactly when more than 3 blocks have been recorded invalid since the last accepted `start`.
- R10: A `start` pulse during a scan has no effect on the request sequence. A `resp_valid` pulse with no request outstanding changes neither the table nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new scan (taken only when idle) |
| req_valid | output | 1 | One-cycle read-request pulse |
| req_addr | output | 19 | Byte address of the marker to read |
| resp_valid | input | 1 | One-cycle pulse: response data is valid |
| resp_data | input | 8 | Marker byte returned by the controller |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | The table is complete |
| lookup_blk | input | 7 | Block number to query |
| lookup_ok | output | 1 | Queried block is usable (one cycle later) |
| excess_bad | output | 1 | More than three blocks are invalid |

## Verification
The state of the table, `done` and `busy` changes on the clock edge that takes the response. A check for them is therefore sampled on the falling edge that follows. The first request of a scan appears one edge after `start` is taken. A response can be taken at the earliest on the second edge after its request. `lookup_ok` has one register stage, so the bench drives `lookup_blk` on a falling edge and reads the answer one full cycle later. A behavioural responder, with response latencies of 1 to 5 cycles that vary per scenario, checks every request address against the order it expects. It also counts the requests per scan, which shows whether the second-page read was skipped.

// File: rtl/badblk_pkg.sv
// Shared definitions for the bad-block scanner.
// Assumes: marker bytes read FFh when the location was never written.
package badblk_pkg;
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_WAIT  = 2'd2
    } scan_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/badblk_addr_gen.sv
// Builds the byte address of a marker from a block number and a page index.
// Assumes: the marker is at column 0 and the page index fits below the block field.
module badblk_addr_gen #(
    parameter int BLK_W      = 7,
    parameter int ADDR_W     = 19,
    parameter int BLK_SHIFT  = 12,
    parameter int PAGE_SHIFT = 7
) (
    input  logic [BLK_W-1:0]  blk,
    input  logic              pg,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Place the block and page fields; every column bit stays 0.
    always_comb begin
        addr = (ADDR_W'(blk) << BLK_SHIFT) | (pg ? (ONE << PAGE_SHIFT) : '0);
    end
endmodule

// File: rtl/badblk_scan_fsm.sv
// Walks every block, issues marker reads and decides which blocks to condemn.
// Assumes: one response per request, a response arrives at least one cycle
// after its request, and block 0 is exempt from marking.
module badblk_scan_fsm
    import badblk_pkg::*;
#(
    parameter int NUM_BLOCKS = 128,
    parameter int BLK_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resp_valid,
    input  logic [7:0]       resp_data,
    output logic             req_valid,
    output logic [BLK_W-1:0] blk,
    output logic             pg,
    output logic             busy,
    output logic             done,
    output logic             clr,
    output logic             mark_we
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t state;
    logic        marker_bad;

    // Classify the returned marker byte.
    always_comb marker_bad = (resp_data != ERASED_BYTE);

    // Sequence the scan through blocks and pages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SC_IDLE;
            blk   <= '0;
            pg    <= 1'b0;
            done  <= 1'b0;
        end else begin
            case (state)
                SC_IDLE: begin
                    if (start) begin
                        state <= SC_ISSUE;
                        blk   <= '0;
                        pg    <= 1'b0;
                        done  <= 1'b0;
                    end
                end
                SC_ISSUE: state <= SC_WAIT;
                SC_WAIT: begin
                    if (resp_valid) begin
                        if (!pg && !marker_bad) begin
                            pg    <= 1'b1;
                            state <= SC_ISSUE;
                        end else if (blk == LAST_BLK) begin
                            state <= SC_IDLE;
                            done  <= 1'b1;
                        end else begin
                            blk   <= blk + 1'b1;
                            pg    <= 1'b0;
                            state <= SC_ISSUE;
                        end
                    end
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    // Decode the control strobes from the current state.
    always_comb begin
        req_valid = (state == SC_ISSUE);
        busy      = (state != SC_IDLE);
        clr       = (state == SC_IDLE) && start;
        mark_we   = (state == SC_WAIT) && resp_valid && marker_bad && (blk != '0);
    end
endmodule

// File: rtl/badblk_table.sv
// Holds one invalid bit per block, counts the marked blocks and answers lookups.
// Assumes: clr and mark_we never occur in the same cycle.
module badblk_table #(
    parameter int NUM_BLOCKS = 128,
    parameter int BLK_W      = 7,
    parameter int MAX_BAD    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mark_we,
    input  logic [BLK_W-1:0] mark_blk,
    input  logic             done,
    input  logic [BLK_W-1:0] lookup_blk,
    output logic             lookup_ok,
    output logic             excess_bad
);
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_BLOCKS);

    logic [NUM_BLOCKS-1:0] bad_bits;
    logic [CNT_W-1:0]      bad_cnt;

    // One storage cell per block, set by a matching mark strobe.
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                bad_bits[i] <= 1'b0;
            end else if (mark_we && (mark_blk == BLK_W'(i))) begin
                bad_bits[i] <= 1'b1;
            end
        end
    end

    // Count the condemned blocks, saturating at the array size.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bad_cnt <= '0;
        end else if (mark_we && bad_cnt != CNT_MAX) begin
            bad_cnt <= bad_cnt + 1'b1;
        end
    end

    // Register the usability answer for the queried block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lookup_ok <= 1'b0;
        end else begin
            lookup_ok <= done && !bad_bits[lookup_blk];
        end
    end

    // Flag an implausible number of bad blocks.
    always_comb excess_bad = (bad_cnt > CNT_W'(MAX_BAD));
endmodule

// File: rtl/badblk_scanner.sv
// Top level: start-up scanner that builds the factory bad-block table.
// Assumes: a controller answers each req_valid pulse with one resp_valid pulse.
module badblk_scanner #(
    parameter int NUM_BLOCKS = 128,
    parameter int ADDR_W     = 19,
    parameter int BLK_SHIFT  = 12,
    parameter int PAGE_SHIFT = 7,
    parameter int MAX_BAD    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          req_valid,
    output logic [ADDR_W-1:0]             req_addr,
    input  logic                          resp_valid,
    input  logic [7:0]                    resp_data,
    output logic                          busy,
    output logic                          done,
    input  logic [$clog2(NUM_BLOCKS)-1:0] lookup_blk,
    output logic                          lookup_ok,
    output logic                          excess_bad
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic [BLK_W-1:0] cur_blk;
    logic             cur_pg;
    logic             tbl_clr;
    logic             tbl_we;

    badblk_scan_fsm #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .req_valid  (req_valid),
        .blk        (cur_blk),
        .pg         (cur_pg),
        .busy       (busy),
        .done       (done),
        .clr        (tbl_clr),
        .mark_we    (tbl_we)
    );

    badblk_addr_gen #(
        .BLK_W      (BLK_W),
        .ADDR_W     (ADDR_W),
        .BLK_SHIFT  (BLK_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_addr (
        .blk  (cur_blk),
        .pg   (cur_pg),
        .addr (req_addr)
    );

    badblk_table #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .MAX_BAD    (MAX_BAD)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tbl_clr),
        .mark_we    (tbl_we),
        .mark_blk   (cur_blk),
        .done       (done),
        .lookup_blk (lookup_blk),
        .lookup_ok  (lookup_ok),
        .excess_bad (excess_bad)
    );
endmodule

// File: rtl/badblk_scanner_chk.sv
// Protocol and result checks on the scanner's ports, bound to every instance.
// Assumes the default 19-bit address layout (block at 18:12, page at bit 7).
module badblk_scanner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        req_valid,
    input logic [18:0] req_addr,
    input logic        resp_valid,
    input logic [7:0]  resp_data,
    input logic        busy,
    input logic        done,
    input logic [6:0]  lookup_blk,
    input logic        lookup_ok,
    input logic        excess_bad
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R3

    AST_REQ_COLUMN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[6:0] == 7'd0 && req_addr[11:8] == 4'd0)); // R3

    AST_FIRST_REQ_BLK0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (req_valid && req_addr == 19'd0)); // R2

    AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_NO_ANSWER_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> !lookup_ok); // R8

    AST_BLOCK0_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lookup_blk == 7'd0) |=> lookup_ok); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !resp_valid) |=> busy); // R10
endmodule

bind badblk_scanner badblk_scanner_chk u_chk (.*);

// File: tb/badblk_scanner_test.sv
module badblk_scanner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid;
    logic [18:0] req_addr;
    logic        resp_valid = 1'b0;
    logic [7:0]  resp_data = 8'hFF;
    logic        busy;
    logic        done;
    logic [6:0]  lookup_blk = 7'd0;
    logic        lookup_ok;
    logic        excess_bad;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    badblk_scanner uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .busy       (busy),
        .done       (done),
        .lookup_blk (lookup_blk),
        .lookup_ok  (lookup_ok),
        .excess_bad (excess_bad)
    );

    // Scenario vectors: page-0 marks, page-1 marks, bad byte value, latency.
    localparam int NSC = 4;
    localparam logic [127:0] SC_M0 [NSC] = '{
        (128'd1 << 5) | (128'd1 << 77),
        (128'd1 << 0),
        (128'd1 << 126) | (128'd1 << 64),
        128'd0
    };
    localparam logic [127:0] SC_M1 [NSC] = '{
        (128'd1 << 127),
        (128'd1 << 0) | (128'd1 << 1) | (128'd1 << 2) | (128'd1 << 3) | (128'd1 << 4),
        (128'd1 << 126),
        128'd0
    };
    localparam logic [7:0] SC_BV  [NSC] = '{8'h00, 8'h7F, 8'hFE, 8'h00};
    localparam int         SC_LAT [NSC] = '{1, 2, 5, 1};

    logic [127:0] cur_m0 = '0;
    logic [127:0] cur_m1 = '0;
    logic [7:0]   cur_bv = 8'h00;
    int           cur_lat = 1;
    int           exp_blk = 0;
    int           exp_pg = 0;
    int           req_cnt = 0;
    int           seq_err = 0;
    logic         stray = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural flash controller: answers each request after cur_lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            if (stray) begin
                resp_valid = 1'b1;
                resp_data  = 8'h00;
                stray      = 1'b0;
            end else if (req_valid) begin
                req_cnt++;
                if (req_addr != 19'((exp_blk << 12) | (exp_pg << 7))) seq_err++;
                repeat (cur_lat) @(negedge clk);
                resp_valid = 1'b1;
                resp_data  = (exp_pg == 0 ? cur_m0[exp_blk] : cur_m1[exp_blk]) ? cur_bv : 8'hFF;
                if (exp_pg == 0 && !cur_m0[exp_blk]) exp_pg = 1;
                else begin exp_blk++; exp_pg = 0; end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic lookup_all(input string tag);
        for (int b = 0; b < 128; b++) begin
            bit expbad;
            expbad = (b != 0) && (cur_m0[b] || cur_m1[b]);
            lookup_blk = 7'(b);
            @(negedge clk);
            chk(lookup_ok == !expbad, (b == 0) ? "R6 block0 usable" : tag, lookup_ok, !expbad);
        end
    endtask

    task automatic run_scenario(input int s, input bit poke_start);
        int exp_reqs;
        int nbad;
        cur_m0  = SC_M0[s];
        cur_m1  = SC_M1[s];
        cur_bv  = SC_BV[s];
        cur_lat = SC_LAT[s];
        exp_blk = 0;
        exp_pg  = 0;
        req_cnt = 0;
        seq_err = 0;
        exp_reqs = 0;
        nbad = 0;
        for (int b = 0; b < 128; b++) begin
            exp_reqs += cur_m0[b] ? 1 : 2;
            if (b != 0 && (cur_m0[b] || cur_m1[b])) nbad++;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R2 start accepted", {busy, done}, 2);
        if (poke_start) begin
            repeat (40) @(negedge clk);
            lookup_blk = 7'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R10 start ignored while busy", busy, 1);
            chk(lookup_ok == 1'b0, "R8 no answer before done", lookup_ok, 0);
        end
        wait_done();
        chk(busy == 1'b0, "R7 busy drops at done", busy, 0);
        chk(exp_blk == 128, "R4 all blocks visited", exp_blk, 128);
        chk(seq_err == 0, "R3 request address order", seq_err, 0);
        chk(req_cnt == exp_reqs, "R4 page-1 skip count", req_cnt, exp_reqs);
        chk(excess_bad == (nbad > 3), "R9 excess flag", excess_bad, nbad > 3);
        lookup_all("R5 table bit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && req_valid == 1'b0, "R1 reset outputs", {done, busy, req_valid}, 0);
        chk(lookup_ok == 1'b0 && excess_bad == 1'b0, "R1 reset flags", {lookup_ok, excess_bad}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0 && busy == 1'b0, "R1 idle after reset", {req_valid, busy}, 0);

        // Vector table walk.
        for (int s = 0; s < NSC; s++) begin
            run_scenario(s, s == 0);
        end

        // Corner: excess scenario again, then all-good rescan clears table.
        run_scenario(1, 1'b0);
        chk(excess_bad == 1'b1, "R9 four bad blocks raise flag", excess_bad, 1);
        run_scenario(3, 1'b0);
        chk(excess_bad == 1'b0, "R2 rescan clears count", excess_bad, 0);

        // Corner: stray response while idle must change nothing.
        cur_m0 = SC_M0[0];
        cur_m1 = SC_M1[0];
        run_scenario(0, 1'b0);
        stray = 1'b1;
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && req_valid == 1'b0, "R10 stray response ignored", {done, req_valid}, 2);
        lookup_all("R10 table kept after stray response");

        // Corner: done persists while idle.
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", done, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule